// File: doc/BRIEF.md
# Multi-Page-Size Data TLB Lookup Unit

This block translates data virtual addresses to physical addresses. It holds a fully associative set of translation entries. Each entry pairs a tag with a translation word. The tag carries a virtual page number and a 13-bit context. The translation word carries a valid flag, a page-size code, a privileged-only flag, a writable flag and a physical page number. Every entry picks its own page size out of four: 8 KB, 64 KB, 512 KB or 4 MB. That choice sets how many low virtual address bits the entry ignores when it compares. It also sets how many offset bits are carried straight from the virtual address into the physical address.

A request strobe starts one lookup against all entries in parallel. One clock later the unit returns one of three outcomes: a translated address with its writable flag, a miss, or a protection fault. When a fault occurs, the unit records the access kind in a sticky fault status register and the virtual address in a fault address register. If an earlier fault has not yet been collected by a read strobe, the status register flags an overflow. A global enable switch turns translation off; the address then passes through unchanged and every access is allowed.

Software loads entries through a write port that takes an index, a tag and a translation word. Choosing which entry to replace, walking the page tables and delivering traps belong to other blocks.

Top module: `tlb_lookup_unit`

## Requirements
- R1: All 64 entries are compared in parallel. An entry matches when tag bits 12:0 equal `ctx` and the virtual address, with the entry's page offset bits cleared, equals tag bits 63:13 with the same offset bits cleared.
- R2: Translation word bits 62:61 select the entry's page size: 0 is 8 KB, 1 is 64 KB, 2 is 512 KB, 3 is 4 MB. The offset is 13, 16, 19 or 22 bits wide.
- R3: On a successful translation, `rsp_pa` bits 40:13 above the page offset come from translation word bits 40:13, and the bits below the page offset come from the virtual address. Translation word bits 63:41 and 12:0 never reach `rsp_pa`, and `rsp_pa` bits 63:41 are zero.
- R4: A matching entry whose translation word bit 63 (valid) is clear produces a fault, not a miss.
- R5: A user access (`req_user`=1) to an entry whose translation word bit 2 is set faults.
- R6: A write (`req_write`=1) to an entry whose translation word bit 1 is clear faults. On a successful translation, `rsp_writable` equals bit 1.
- R7: With translation enabled and no matching entry, `rsp_miss` is raised, and `fsr` and `far` are left unchanged. On a miss or a fault, `rsp_pa` is 0 and `rsp_writable` is 0. `rsp_miss` and `rsp_fault` are never raised together.
- R8: With `xlate_en` low, `rsp_pa` equals the virtual address, `rsp_writable` is 1, there is no miss or fault, and `fsr`/`far` are untouched.
- R9: On a fault, `fsr` is first set to 2 if it was nonzero (overflow). It is then ORed with `req_user` in bit 3, `req_write` in bit 2 and a 1 in bit 0. `far` takes the faulting virtual address.
- R10: `fsr_rd` clears `fsr` to 0 on the next edge. If a fault is recorded in that same cycle, the fault is written as if `fsr` had been zero, with no overflow.
- R11: `rsp_valid` is high for exactly the one cycle after a cycle with `req` high. The response outputs are loaded only on requests and otherwise hold their values.
- R12: An entry written through `ent_we` is seen by a lookup requested in the very next cycle.
- R13: When several entries match, the lowest-index entry decides the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Translation enable; low passes addresses through |
| ctx | input | 13 | Current context compared against tags |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | 6 | Entry index to write |
| ent_tag | input | 64 | Tag: virtual page in 63:13, context in 12:0 |
| ent_word | input | 64 | Translation word: valid 63, size 62:61, physical page 40:13, privileged 2, writable 1 |
| req | input | 1 | Lookup request strobe |
| req_va | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| fsr_rd | input | 1 | Fault status read strobe (clears it) |
| rsp_valid | output | 1 | Response valid, one cycle after `req` |
| rsp_pa | output | 64 | Physical address |
| rsp_writable | output | 1 | Page may be written |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Protection or invalid-entry fault |
| fsr | output | 4 | Fault status register |
| far | output | 64 | Fault address register |

## Verification
The overflow encoding of the status register is the hardest state to reach from the ports. It needs two faults in a row with no read strobe between them. A read strobe in the same cycle as a fault must also yield a fresh record rather than an overflow. The bench first clears the register and then raises a user write fault on a privileged page. It follows with a user read fault on the same page, then a miss that must leave both registers alone. Last, it drives the read strobe together with a write-protection fault. The page-size masks are reached through entries placed so that an address one page past an entry misses while the last byte inside it hits. A deliberately duplicated tag and a translation word with stray high bits cover priority and physical-field trimming.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int VA_W     = 64;
  localparam int CTX_W    = 13;
  localparam int PA_W     = 41;
  localparam int OFS_BASE = 13;
  localparam int VPN_W    = VA_W - OFS_BASE;
  localparam int PPN_W    = PA_W - OFS_BASE;
  localparam int SZ_STEP  = 3;
  localparam int FSR_W    = 4;

  // translation word field positions (decoded at the write port)
  localparam int W_VALID  = 63;
  localparam int W_SZ_HI  = 62;
  localparam int W_SZ_LO  = 61;
  localparam int W_PRIV   = 2;
  localparam int W_WR     = 1;

  // fault status bit positions
  localparam int FS_VLD   = 0;
  localparam int FS_OVF   = 1;
  localparam int FS_WR    = 2;
  localparam int FS_USR   = 3;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [CTX_W-1:0] ctx;
  } tag_t;

  typedef struct packed {
    logic             valid;
    logic [1:0]       size;
    logic             priv;
    logic             wr;
    logic [PPN_W-1:0] ppn;
  } xlat_t;

  // ones on virtual page bits kept for the compare
  function automatic logic [VPN_W-1:0] vpn_keep(input logic [1:0] sz);
    return {VPN_W{1'b1}} << (SZ_STEP * int'(sz));
  endfunction

  // ones on physical page bits taken from the translation word
  function automatic logic [PPN_W-1:0] ppn_keep(input logic [1:0] sz);
    return {PPN_W{1'b1}} << (SZ_STEP * int'(sz));
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
`timescale 1ns/1ps
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  tag_t             tag_in,
  input  xlat_t            xlat_in,
  output tag_t             tags  [ENTRIES],
  output xlat_t            xlats [ENTRIES]
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic  sel;
    tag_t  tag_q;
    xlat_t xlat_q;

    assign sel = we && (idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q  <= '0;
        xlat_q <= '0;
      end else if (sel) begin
        tag_q  <= tag_in;
        xlat_q <= xlat_in;
      end
    end

    assign tags[e]  = tag_q;
    assign xlats[e] = xlat_q;
  end

endmodule

// File: rtl/tlb_tag_match.sv
`timescale 1ns/1ps
module tlb_tag_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic [VPN_W-1:0] va_vpn,
  input  logic [CTX_W-1:0] ctx,
  input  tag_t             tags    [ENTRIES],
  input  logic [1:0]       sizes   [ENTRIES],
  output logic [ENTRIES-1:0] hit
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [VPN_W-1:0] keep;
    logic             ctx_eq;
    logic             page_eq;

    always_comb begin
      keep    = vpn_keep(sizes[e]);
      ctx_eq  = (tags[e].ctx == ctx);
      page_eq = ((va_vpn & keep) == (tags[e].vpn & keep));
      hit[e]  = ctx_eq && page_eq;
    end
  end

endmodule

// File: rtl/tlb_pick_first.sv
`timescale 1ns/1ps
module tlb_pick_first #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/tlb_fault_log.sv
`timescale 1ns/1ps
module tlb_fault_log
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_evt,
  input  logic             rd_clr,
  input  logic             acc_user,
  input  logic             acc_write,
  input  logic [VA_W-1:0]  acc_va,
  output logic [FSR_W-1:0] fsr,
  output logic [VA_W-1:0]  far
);

  logic [FSR_W-1:0] fsr_q, fsr_d, fsr_base;
  logic [VA_W-1:0]  far_q, far_d;
  logic             fsr_en;

  always_comb begin
    fsr_base = rd_clr ? '0 : fsr_q;
    fsr_d    = fsr_base;
    far_d    = far_q;
    if (fault_evt) begin
      if (fsr_base != '0) begin
        fsr_d = '0;
        fsr_d[FS_OVF] = 1'b1;
      end
      fsr_d[FS_USR] = fsr_d[FS_USR] | acc_user;
      fsr_d[FS_WR]  = fsr_d[FS_WR]  | acc_write;
      fsr_d[FS_VLD] = 1'b1;
      far_d = acc_va;
    end
    fsr_en = fault_evt || rd_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else begin
      if (fsr_en) fsr_q <= fsr_d;
      if (fault_evt) far_q <= far_d;
    end
  end

  assign fsr = fsr_q;
  assign far = far_q;

endmodule

// File: rtl/tlb_lookup_unit.sv
`timescale 1ns/1ps
module tlb_lookup_unit
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xlate_en,
  input  logic [CTX_W-1:0] ctx,
  input  logic             ent_we,
  input  logic [IDX_W-1:0] ent_idx,
  input  logic [VA_W-1:0]  ent_tag,
  input  logic [VA_W-1:0]  ent_word,
  input  logic             req,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_user,
  input  logic             fsr_rd,
  output logic             rsp_valid,
  output logic [VA_W-1:0]  rsp_pa,
  output logic             rsp_writable,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [FSR_W-1:0] fsr,
  output logic [VA_W-1:0]  far
);

  // write-port decode: only the fields the lookup uses are stored
  tag_t  wr_tag;
  xlat_t wr_xlat;

  always_comb begin
    wr_tag.vpn    = ent_tag[VA_W-1:OFS_BASE];
    wr_tag.ctx    = ent_tag[CTX_W-1:0];
    wr_xlat.valid = ent_word[W_VALID];
    wr_xlat.size  = ent_word[W_SZ_HI:W_SZ_LO];
    wr_xlat.priv  = ent_word[W_PRIV];
    wr_xlat.wr    = ent_word[W_WR];
    wr_xlat.ppn   = ent_word[PA_W-1:OFS_BASE];
  end

  tag_t  tags  [ENTRIES];
  xlat_t xlats [ENTRIES];
  logic [1:0] sizes [ENTRIES];

  tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ent_we),
    .idx     (ent_idx),
    .tag_in  (wr_tag),
    .xlat_in (wr_xlat),
    .tags    (tags),
    .xlats   (xlats)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_sz
    assign sizes[e] = xlats[e].size;
  end

  logic [ENTRIES-1:0] hit_vec;

  tlb_tag_match #(.ENTRIES(ENTRIES)) u_match (
    .va_vpn (req_va[VA_W-1:OFS_BASE]),
    .ctx    (ctx),
    .tags   (tags),
    .sizes  (sizes),
    .hit    (hit_vec)
  );

  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;

  tlb_pick_first #(.ENTRIES(ENTRIES)) u_pick (
    .hit   (hit_vec),
    .found (hit_any),
    .idx   (hit_idx)
  );

  // next-state of the response
  xlat_t            sel_x;
  logic [PPN_W-1:0] keep;
  logic [PA_W-1:0]  pa_hit;
  logic             viol;
  logic [VA_W-1:0]  pa_d;
  logic             wr_d, miss_d, fault_d;
  logic             fault_evt;

  always_comb begin
    sel_x  = xlats[hit_idx];
    keep   = ppn_keep(sel_x.size);
    pa_hit = {(sel_x.ppn & keep) | (req_va[PA_W-1:OFS_BASE] & ~keep),
              req_va[OFS_BASE-1:0]};
    viol   = !sel_x.valid || (sel_x.priv && req_user) || (!sel_x.wr && req_write);

    pa_d    = '0;
    wr_d    = 1'b0;
    miss_d  = 1'b0;
    fault_d = 1'b0;
    if (!xlate_en) begin
      pa_d = req_va;
      wr_d = 1'b1;
    end else if (!hit_any) begin
      miss_d = 1'b1;
    end else if (viol) begin
      fault_d = 1'b1;
    end else begin
      pa_d = VA_W'(pa_hit);
      wr_d = sel_x.wr;
    end
    fault_evt = req && fault_d;
  end

  // response registers
  logic            valid_q, wr_q, miss_q, fault_q;
  logic [VA_W-1:0] pa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pa_q    <= '0;
      wr_q    <= 1'b0;
      miss_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      valid_q <= req;
      if (req) begin
        pa_q    <= pa_d;
        wr_q    <= wr_d;
        miss_q  <= miss_d;
        fault_q <= fault_d;
      end
    end
  end

  assign rsp_valid    = valid_q;
  assign rsp_pa       = pa_q;
  assign rsp_writable = wr_q;
  assign rsp_miss     = miss_q;
  assign rsp_fault    = fault_q;

  tlb_fault_log u_flog (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_evt (fault_evt),
    .rd_clr    (fsr_rd),
    .acc_user  (req_user),
    .acc_write (req_write),
    .acc_va    (req_va),
    .fsr       (fsr),
    .far       (far)
  );

endmodule

// File: rtl/tlb_lookup_unit_chk.sv
`timescale 1ns/1ps
module tlb_lookup_unit_chk
  import tlb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             xlate_en,
  input logic             req,
  input logic [VA_W-1:0]  req_va,
  input logic             fsr_rd,
  input logic             rsp_valid,
  input logic [VA_W-1:0]  rsp_pa,
  input logic             rsp_writable,
  input logic             rsp_miss,
  input logic             rsp_fault,
  input logic [FSR_W-1:0] fsr,
  input logic [VA_W-1:0]  far
);

  assert_rsp_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);
  assert_rsp_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(rsp_pa) && $stable(rsp_miss) && $stable(rsp_fault)));

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_miss && rsp_fault));
  assert_fail_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss || rsp_fault) |-> (rsp_pa == '0 && !rsp_writable));
  assert_miss_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss && !$past(fsr_rd)) |-> ($stable(fsr) && $stable(far)));

  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !xlate_en) |=>
      (!rsp_miss && !rsp_fault && rsp_writable && rsp_pa == $past(req_va)));

  assert_fault_logged_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> fsr[FS_VLD]);
  assert_far_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (!rsp_fault || far == $past(req_va)));
  assert_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fsr != '0 && !fsr_rd) |=> (!rsp_fault || fsr[FS_OVF]));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_rd && !req) |=> (fsr == '0));

endmodule

bind tlb_lookup_unit tlb_lookup_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .xlate_en     (xlate_en),
  .req          (req),
  .req_va       (req_va),
  .fsr_rd       (fsr_rd),
  .rsp_valid    (rsp_valid),
  .rsp_pa       (rsp_pa),
  .rsp_writable (rsp_writable),
  .rsp_miss     (rsp_miss),
  .rsp_fault    (rsp_fault),
  .fsr          (fsr),
  .far          (far)
);

// File: tb/tb_tlb_lookup_unit.sv
`timescale 1ns/1ps
module tb_tlb_lookup_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b1;
  logic [12:0] ctx = '0;
  logic        ent_we = 1'b0;
  logic [5:0]  ent_idx = '0;
  logic [63:0] ent_tag = '0;
  logic [63:0] ent_word = '0;
  logic        req = 1'b0;
  logic [63:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        fsr_rd = 1'b0;
  logic        rsp_valid, rsp_writable, rsp_miss, rsp_fault;
  logic [63:0] rsp_pa, far;
  logic [3:0]  fsr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  tlb_lookup_unit dut (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .ctx(ctx),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_tag(ent_tag), .ent_word(ent_word),
    .req(req), .req_va(req_va), .req_write(req_write), .req_user(req_user),
    .fsr_rd(fsr_rd), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .rsp_writable(rsp_writable), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .fsr(fsr), .far(far)
  );

  typedef struct packed {
    logic [63:0] va;
    logic [12:0] cx;
    logic        wr;
    logic        usr;
    logic        e_miss;
    logic        e_fault;
    logic        e_wr;
    logic [63:0] e_pa;
    logic [3:0]  rq;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    // R1 R2: 8 KB page hit, and last byte of the page
    '{va:64'h400ABC,   cx:13'd5, wr:1'b0, usr:1'b1, e_miss:1'b0, e_fault:1'b0, e_wr:1'b1, e_pa:64'h1_2345_6ABC, rq:4'd1},
    '{va:64'h401FFF,   cx:13'd5, wr:1'b1, usr:1'b1, e_miss:1'b0, e_fault:1'b0, e_wr:1'b1, e_pa:64'h1_2345_7FFF, rq:4'd2},
    // R7: next 8 KB page misses; R1: wrong context misses
    '{va:64'h402000,   cx:13'd5, wr:1'b0, usr:1'b0, e_miss:1'b1, e_fault:1'b0, e_wr:1'b0, e_pa:64'h0, rq:4'd7},
    '{va:64'h400ABC,   cx:13'd6, wr:1'b0, usr:1'b0, e_miss:1'b1, e_fault:1'b0, e_wr:1'b0, e_pa:64'h0, rq:4'd1},
    // R3 R6: 64 KB read-only page
    '{va:64'h1234ABCD, cx:13'd5, wr:1'b0, usr:1'b1, e_miss:1'b0, e_fault:1'b0, e_wr:1'b0, e_pa:64'hABCD_ABCD, rq:4'd3},
    '{va:64'h1234FFFF, cx:13'd5, wr:1'b1, usr:1'b1, e_miss:1'b0, e_fault:1'b1, e_wr:1'b0, e_pa:64'h0, rq:4'd6},
    // R2 R5: 512 KB privileged page
    '{va:64'h800F1234, cx:13'd5, wr:1'b0, usr:1'b0, e_miss:1'b0, e_fault:1'b0, e_wr:1'b1, e_pa:64'h1_0007_1234, rq:4'd2},
    '{va:64'h800F1234, cx:13'd5, wr:1'b0, usr:1'b1, e_miss:1'b0, e_fault:1'b1, e_wr:1'b0, e_pa:64'h0, rq:4'd5},
    // R2: 4 MB page, top byte hits, next page misses
    '{va:64'hC03FFFFF, cx:13'd7, wr:1'b1, usr:1'b0, e_miss:1'b0, e_fault:1'b0, e_wr:1'b1, e_pa:64'h1_FFFF_FFFF, rq:4'd2},
    '{va:64'hC0400000, cx:13'd7, wr:1'b0, usr:1'b0, e_miss:1'b1, e_fault:1'b0, e_wr:1'b0, e_pa:64'h0, rq:4'd2},
    // R4: invalid matching entry faults
    '{va:64'h500010,   cx:13'd5, wr:1'b0, usr:1'b0, e_miss:1'b0, e_fault:1'b1, e_wr:1'b0, e_pa:64'h0, rq:4'd4},
    // R13: duplicate tag, lowest index wins
    '{va:64'h600123,   cx:13'd5, wr:1'b0, usr:1'b0, e_miss:1'b0, e_fault:1'b0, e_wr:1'b1, e_pa:64'h2123, rq:4'd13},
    // R3: stray word bits above 40 and at bit 12 are dropped
    '{va:64'h701234,   cx:13'd5, wr:1'b0, usr:1'b0, e_miss:1'b0, e_fault:1'b0, e_wr:1'b1, e_pa:64'h3234, rq:4'd3}
  };

  task automatic chk(input bit ok, input string rq, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic write_entry(input int idx, input logic [63:0] tag, input logic [63:0] word);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = 6'(idx); ent_tag = tag; ent_word = word;
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  task automatic lookup(input logic [63:0] va, input logic [12:0] c, input logic w, input logic u, input logic rd);
    @(negedge clk);
    req = 1'b1; req_va = va; ctx = c; req_write = w; req_user = u; fsr_rd = rd;
    @(negedge clk);
    req = 1'b0; fsr_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R11 R9)
    chk(!rsp_valid && !rsp_miss && !rsp_fault, "R11 reset outputs",
        {65'd0, rsp_valid, rsp_miss, rsp_fault}, 68'd0);
    chk(fsr == 4'd0 && far == 64'd0, "R9 reset fault regs", {fsr, far}, 68'd0);

    write_entry(0,  64'h0040_0005,  64'h8000_0001_2345_6002);
    write_entry(1,  64'h1234_0005,  64'hA000_0000_ABCD_0000);
    write_entry(2,  64'h8008_0005,  64'hC000_0001_0000_0006);
    write_entry(3,  64'hC000_0007,  64'hE000_0001_FFC0_0002);
    write_entry(4,  64'h0050_0005,  64'h0000_0000_0777_0002);
    write_entry(5,  64'h0070_0005,  64'h8FFF_FE00_0000_3002);
    write_entry(10, 64'h0060_0005,  64'h8000_0000_0000_2002);
    write_entry(20, 64'h0060_0005,  64'h8000_0000_0000_4000);

    for (int i = 0; i < NVEC; i++) begin
      lookup(VECS[i].va, VECS[i].cx, VECS[i].wr, VECS[i].usr, 1'b0);
      checks++;
      if ({rsp_miss, rsp_fault, rsp_writable, rsp_pa} !=
          {VECS[i].e_miss, VECS[i].e_fault, VECS[i].e_wr, VECS[i].e_pa}) begin
        errors++;
        $display("FAIL R%0d vector %0d actual m%b f%b w%b %h expected m%b f%b w%b %h",
                 VECS[i].rq, i, rsp_miss, rsp_fault, rsp_writable, rsp_pa,
                 VECS[i].e_miss, VECS[i].e_fault, VECS[i].e_wr, VECS[i].e_pa);
      end
    end

    // R10: read strobe clears status
    @(negedge clk); fsr_rd = 1'b1;
    @(negedge clk); fsr_rd = 1'b0;
    chk(fsr == 4'd0, "R10 clear", {64'd0, fsr}, 68'd0);

    // R9: first fault, user write on privileged page
    lookup(64'h8008_0010, 13'd5, 1'b1, 1'b1, 1'b0);
    chk(rsp_fault && fsr == 4'hD, "R9 first fault status", {64'd0, fsr}, 68'hD);
    chk(far == 64'h8008_0010, "R9 fault address", {4'd0, far}, {4'd0, 64'h8008_0010});

    // R9: second fault without a read flags overflow
    lookup(64'h8009_0000, 13'd5, 1'b0, 1'b1, 1'b0);
    chk(fsr == 4'hB, "R9 overflow status", {64'd0, fsr}, 68'hB);
    chk(far == 64'h8009_0000, "R9 second fault address", {4'd0, far}, {4'd0, 64'h8009_0000});

    // R7: a miss leaves both registers alone
    lookup(64'h9000_0000, 13'd5, 1'b1, 1'b1, 1'b0);
    chk(rsp_miss && !rsp_fault, "R7 miss flag", {66'd0, rsp_miss, rsp_fault}, 68'h2);
    chk(fsr == 4'hB && far == 64'h8009_0000, "R7 miss keeps fault regs",
        {fsr, far}, {4'hB, 64'h8009_0000});

    // R10: read strobe together with a fault records it fresh
    lookup(64'h1234_0000, 13'd5, 1'b1, 1'b0, 1'b1);
    chk(rsp_fault && fsr == 4'h5, "R10 same-cycle fault", {64'd0, fsr}, 68'h5);

    // R8: bypass
    xlate_en = 1'b0;
    lookup(64'hDEAD_BEEF_0000_1234, 13'd5, 1'b1, 1'b1, 1'b0);
    chk(!rsp_miss && !rsp_fault && rsp_writable && rsp_pa == 64'hDEAD_BEEF_0000_1234,
        "R8 bypass", {1'b0, rsp_miss, rsp_fault, rsp_writable, rsp_pa},
        {4'b0001, 64'hDEAD_BEEF_0000_1234});
    chk(fsr == 4'h5 && far == 64'h1234_0000, "R8 bypass keeps fault regs",
        {fsr, far}, {4'h5, 64'h1234_0000});
    xlate_en = 1'b1;

    // R11: idle cycles drop valid and hold the result
    @(negedge clk);
    chk(!rsp_valid && rsp_pa == 64'hDEAD_BEEF_0000_1234, "R11 hold",
        {3'd0, rsp_valid, rsp_pa}, {4'd0, 64'hDEAD_BEEF_0000_1234});

    // R12: entry written one cycle before the lookup is seen
    lookup(64'h0AA0_0123, 13'd9, 1'b0, 1'b0, 1'b0);
    chk(rsp_miss, "R12 before write", {67'd0, rsp_miss}, 68'd1);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = 6'd30; ent_tag = 64'h0AA0_0009; ent_word = 64'h8000_0005_5550_0002;
    @(negedge clk);
    ent_we = 1'b0;
    req = 1'b1; req_va = 64'h0AA0_0123; ctx = 13'd9; req_write = 1'b0; req_user = 1'b0;
    @(negedge clk);
    req = 1'b0;
    chk(rsp_valid && !rsp_miss && rsp_pa == 64'h5_5550_0123, "R12 next-cycle hit",
        {2'd0, rsp_valid, rsp_miss, rsp_pa}, {4'b0010, 64'h5_5550_0123});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule